// File: doc/BRIEF.md
# Serial Wire Debug Host Access Engine

This block runs one Serial Wire Debug access at bit level, on behalf of a controller that sits above it. A single command carries the direction, the port selection (debug port or access port), a two-bit register address and 32 bits of write data. The block generates the debug clock from the system clock and drives the bidirectional data line through separate out, in and output-enable signals. It shifts out the request header, releases the line for a turnaround, reads the target's three-bit acknowledge, and then moves the 32-bit data word with its parity bit.

A WAIT or FAULT acknowledge makes the block send the whole request again, up to a bounded number of attempts. When the command ends, the block returns the read data and a status code and pulses `done`. If an earlier access failed, a sticky flag stays set. While it is set, access-port commands are rejected at once, so the controller must first complete a successful debug-port access, for example a write that clears errors. Line reset, protocol switch sequences and target discovery belong to the controller.

Top module: `swd_host_engine`

## Requirements
- R1: The 8-bit request header is, from bit 0 to bit 7: start = 1, port select (1 = access port), direction (1 = read), address bit A2 (`cmd_addr[0]`), address bit A3 (`cmd_addr[1]`), even parity over bits 1 to 4, stop = 0, park = 1.
- R2: Every bit goes out LSB first. The host changes SWDIO only while SWCLK is low and samples it on the rising edge. After the 8 header bits the host releases the line for one turnaround cycle. It then samples three acknowledge bits, first bit in the LSB, where OK = 3'b001, WAIT = 3'b010 and FAULT = 3'b100.
- R3: A write with an OK acknowledge continues as follows: one released turnaround cycle, 32 data bits driven LSB first, a bit equal to the XOR of the data, then 8 cycles driven low. After that, `done` pulses with status 0. In total the write uses 54 SWCLK rising edges.
- R4: A read with an OK acknowledge samples 32 data bits and a parity bit and adds one released turnaround cycle, 46 rising edges in all. It returns the data on `rdata` with status 0 when the parity bit equals the XOR of the data.
- R5: If the parity of a read does not match, the status is 4 (parity error) and `rdata` is zero.
- R6: After a WAIT or FAULT acknowledge, one released turnaround cycle follows and the full request header is sent again. This repeats until an OK acknowledge arrives, with at most MAX_TRIES attempts in total.
- R7: When MAX_TRIES attempts have all failed, the status reports the last acknowledge: 1 for WAIT, 2 for FAULT. `rdata` is zero.
- R8: An acknowledge of 3'b111 ends the command with status 3 (no response). Any other code that is not OK, WAIT or FAULT ends it with status 5 (invalid acknowledge). Neither is retried.
- R9: Any command that ends with a status other than 0 sets a sticky fault flag. While the flag is set, an access-port command finishes one cycle after `start` with status 2 and `rdata` zero, and produces no SWCLK edge. A debug-port command still runs, and if it ends with status 0 it clears the flag.
- R10: Out of reset, and whenever the block is not busy, SWCLK is low, SWDIO is released and `busy` is low. `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a command; sampled when not busy |
| cmd_rnw | input | 1 | 1 = read, 0 = write |
| cmd_ap | input | 1 | 1 = access port, 0 = debug port |
| cmd_addr | input | 2 | Register address bits A[3:2] |
| cmd_wdata | input | 32 | Write data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | 0 ok, 1 wait timeout, 2 fault, 3 no response, 4 parity error, 5 invalid ack |
| rdata | output | 32 | Read data, zero unless a read ended with status 0 |
| swclk | output | 1 | Debug clock |
| swdio_out | output | 1 | Data line value driven by the host |
| swdio_oe | output | 1 | Host drives the data line when high |
| swdio_in | input | 1 | Data line value seen at the pin |

## Verification
The hardest situations to reach are the retry and sticky-flag paths. They need a target that answers differently on successive attempts of the same command, and the command after a failure has to be issued while the flag is still set. The bench contains a target model that counts SWCLK rising edges within each attempt. It can be told to answer WAIT or FAULT for a chosen number of attempts before a final code, and it can flip the read parity bit. The test order then places access-port commands immediately after failures and debug-port commands after them to clear the flag.

// File: rtl/swd_host_pkg.sv
package swd_host_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_TRN1, S_ACK, S_TRN2, S_WDATA, S_WIDLE, S_RDATA, S_TRN3, S_FIN
  } swd_state_e;

  typedef enum logic [2:0] {
    ST_OK      = 3'd0,
    ST_WAIT_TO = 3'd1,
    ST_FAULT   = 3'd2,
    ST_NO_RESP = 3'd3,
    ST_PARITY  = 3'd4,
    ST_BAD_ACK = 3'd5
  } swd_status_e;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;
  localparam logic [2:0] ACK_NONE  = 3'b111;

  localparam logic [7:0] HDR_BASE    = 8'h81;
  localparam logic [7:0] HDR_AP_FLIP = 8'h22;
  localparam logic [7:0] HDR_RD_FLIP = 8'h24;
  localparam logic [7:0] HDR_PARITY  = 8'h20;

endpackage

// File: rtl/swd_req_header.sv
module swd_req_header
  import swd_host_pkg::*;
(
  input  logic       rnw,
  input  logic       ap,
  input  logic [1:0] addr,
  output logic [7:0] hdr
);
  // Parity tracks each field by toggling bit 5 together with the field bit.
  always_comb begin
    hdr = HDR_BASE;
    if (ap)  hdr = hdr ^ HDR_AP_FLIP;
    if (rnw) hdr = hdr ^ HDR_RD_FLIP;
    hdr[4:3] = addr;
    if (addr[0] ^ addr[1]) hdr = hdr ^ HDR_PARITY;
  end
endmodule

// File: rtl/swd_ack_decode.sv
module swd_ack_decode
  import swd_host_pkg::*;
(
  input  logic [2:0]  ack,
  output logic        ack_ok,
  output logic        ack_retry,
  output swd_status_e ack_st
);
  always_comb begin
    ack_ok    = 1'b0;
    ack_retry = 1'b0;
    case (ack)
      ACK_OK:    begin ack_ok = 1'b1; ack_st = ST_OK; end
      ACK_WAIT:  begin ack_retry = 1'b1; ack_st = ST_WAIT_TO; end
      ACK_FAULT: begin ack_retry = 1'b1; ack_st = ST_FAULT; end
      ACK_NONE:  ack_st = ST_NO_RESP;
      default:   ack_st = ST_BAD_ACK;
    endcase
  end
endmodule

// File: rtl/swd_tick_gen.sv
module swd_tick_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine
  import swd_host_pkg::*;
#(
  parameter int HALF_DIV  = 2,
  parameter int MAX_TRIES = 64,
  parameter int DW        = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          cmd_rnw,
  input  logic          cmd_ap,
  input  logic [1:0]    cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          busy,
  output logic          done,
  output logic [2:0]    status,
  output logic [DW-1:0] rdata,
  output logic          swclk,
  output logic          swdio_out,
  output logic          swdio_oe,
  input  logic          swdio_in
);
  localparam int TW = $clog2(MAX_TRIES + 1);
  localparam int IW = $clog2(DW + 1);
  localparam int AW = (DW > 1) ? $clog2(DW) : 1;

  swd_state_e    state;
  logic [IW-1:0] idx;
  logic [7:0]    hdr_q, hdr_w;
  logic [DW-1:0] wdata_q, rsh;
  logic          rnw_q, ap_q;
  logic [2:0]    ack_q, ack_now;
  logic [TW-1:0] try_cnt;
  logic          retry_q, sticky_q;
  swd_status_e   fin_st, status_q;
  logic          swclk_q, out_q, oe_q, done_q;
  logic [DW-1:0] rdata_q;
  logic          tick, ack_ok, ack_retry;
  swd_status_e   ack_st;
  logic          drv_out, drv_oe;

  swd_req_header hdr_i (.rnw(cmd_rnw), .ap(cmd_ap), .addr(cmd_addr), .hdr(hdr_w));

  assign ack_now = {swdio_in, ack_q[1:0]};
  swd_ack_decode dec_i (.ack(ack_now), .ack_ok(ack_ok), .ack_retry(ack_retry), .ack_st(ack_st));

  swd_tick_gen #(.HALF_DIV(HALF_DIV)) tick_i (.clk(clk), .rst(rst), .en(busy), .tick(tick));

  assign busy      = (state != S_IDLE);
  assign done      = done_q;
  assign status    = status_q;
  assign rdata     = rdata_q;
  assign swclk     = swclk_q;
  assign swdio_out = out_q;
  assign swdio_oe  = oe_q;

  // Value to place on the line at the next falling edge
  always_comb begin
    drv_out = 1'b0;
    drv_oe  = 1'b0;
    case (state)
      S_HDR:   begin drv_oe = 1'b1; drv_out = hdr_q[idx[2:0]]; end
      S_WDATA: begin
        drv_oe  = 1'b1;
        drv_out = (idx == IW'(DW)) ? ^wdata_q : wdata_q[idx[AW-1:0]];
      end
      S_WIDLE: drv_oe = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    done_q <= 1'b0;
    if (rst) begin
      state    <= S_IDLE;
      idx      <= '0;
      hdr_q    <= '0;
      wdata_q  <= '0;
      rsh      <= '0;
      rnw_q    <= 1'b0;
      ap_q     <= 1'b0;
      ack_q    <= '0;
      try_cnt  <= '0;
      retry_q  <= 1'b0;
      sticky_q <= 1'b0;
      fin_st   <= ST_OK;
      status_q <= ST_OK;
      rdata_q  <= '0;
      swclk_q  <= 1'b0;
      out_q    <= 1'b0;
      oe_q     <= 1'b0;
    end else if (state == S_IDLE) begin
      if (start) begin
        if (cmd_ap && sticky_q) begin
          done_q   <= 1'b1;
          status_q <= ST_FAULT;
          rdata_q  <= '0;
        end else begin
          state   <= S_HDR;
          idx     <= '0;
          hdr_q   <= hdr_w;
          wdata_q <= cmd_wdata;
          rnw_q   <= cmd_rnw;
          ap_q    <= cmd_ap;
          try_cnt <= TW'(1);
          retry_q <= 1'b0;
          out_q   <= hdr_w[0];
          oe_q    <= 1'b1;
        end
      end
    end else if (tick) begin
      swclk_q <= ~swclk_q;
      if (swclk_q) begin
        // falling edge: present the next bit or finish
        if (state == S_FIN) begin
          done_q   <= 1'b1;
          status_q <= fin_st;
          rdata_q  <= (rnw_q && fin_st == ST_OK) ? rsh : '0;
          if (fin_st != ST_OK) sticky_q <= 1'b1;
          else if (!ap_q)      sticky_q <= 1'b0;
          state <= S_IDLE;
          out_q <= 1'b0;
          oe_q  <= 1'b0;
        end else begin
          out_q <= drv_out;
          oe_q  <= drv_oe;
        end
      end else begin
        // rising edge: sample and advance
        case (state)
          S_HDR: begin
            if (idx == IW'(7)) begin state <= S_TRN1; idx <= '0; end
            else idx <= idx + 1'b1;
          end
          S_TRN1: begin state <= S_ACK; idx <= '0; end
          S_ACK: begin
            ack_q[idx[1:0]] <= swdio_in;
            if (idx == IW'(2)) begin
              idx <= '0;
              if (ack_ok) begin
                fin_st  <= ST_OK;
                retry_q <= 1'b0;
                state   <= rnw_q ? S_RDATA : S_TRN2;
              end else begin
                fin_st  <= ack_st;
                retry_q <= ack_retry && (try_cnt < TW'(MAX_TRIES));
                state   <= S_TRN3;
              end
            end else idx <= idx + 1'b1;
          end
          S_TRN2: begin state <= S_WDATA; idx <= '0; end
          S_WDATA: begin
            if (idx == IW'(DW)) begin state <= S_WIDLE; idx <= '0; end
            else idx <= idx + 1'b1;
          end
          S_WIDLE: begin
            if (idx == IW'(7)) begin state <= S_FIN; idx <= '0; end
            else idx <= idx + 1'b1;
          end
          S_RDATA: begin
            if (idx == IW'(DW)) begin
              fin_st <= (swdio_in == ^rsh) ? ST_OK : ST_PARITY;
              state  <= S_TRN3;
              idx    <= '0;
            end else begin
              rsh[idx[AW-1:0]] <= swdio_in;
              idx <= idx + 1'b1;
            end
          end
          S_TRN3: begin
            if (retry_q) begin
              state   <= S_HDR;
              idx     <= '0;
              try_cnt <= try_cnt + 1'b1;
              retry_q <= 1'b0;
            end else state <= S_FIN;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/swd_host_engine_chk.sv
module swd_host_engine_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          cmd_ap,
  input logic          busy,
  input logic          done,
  input logic [2:0]    status,
  input logic [DW-1:0] rdata,
  input logic          swclk,
  input logic          swdio_out,
  input logic          swdio_oe,
  input logic          sticky_q
);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!swclk && !swdio_oe));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_out_on_low_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(swdio_out) |-> !swclk);

  p_oe_on_low_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(swdio_oe) |-> !swclk);

  p_refuse_r9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && cmd_ap && sticky_q) |=> (done && status == 3'd2 && rdata == '0 && !busy));

  p_sticky_set_r9: assert property (@(posedge clk) disable iff (rst)
    (done && status != 3'd0) |=> sticky_q);

  p_parity_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (done && status == 3'd4) |-> rdata == '0);

  p_fail_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (done && status != 3'd0) |-> rdata == '0);

  p_status_range_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> status <= 3'd5);
endmodule

bind swd_host_engine swd_host_engine_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .start(start), .cmd_ap(cmd_ap), .busy(busy), .done(done),
  .status(status), .rdata(rdata), .swclk(swclk), .swdio_out(swdio_out),
  .swdio_oe(swdio_oe), .sticky_q(sticky_q)
);

// File: tb/swd_host_engine_tb.sv
module swd_host_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TRIES      = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        cmd_rnw = 1'b0, cmd_ap = 1'b0;
  logic [1:0]  cmd_addr = 2'd0;
  logic [31:0] cmd_wdata = '0;
  logic        busy, done, swclk, swdio_out, swdio_oe;
  logic [2:0]  status;
  logic [31:0] rdata;
  logic        swdio_in = 1'b0;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swd_host_engine #(.HALF_DIV(2), .MAX_TRIES(TRIES)) dut_i (
    .clk(clk), .rst(rst), .start(start), .cmd_rnw(cmd_rnw), .cmd_ap(cmd_ap),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .status(status), .rdata(rdata), .swclk(swclk), .swdio_out(swdio_out),
    .swdio_oe(swdio_oe), .swdio_in(swdio_in)
  );

  // Target model configuration (written by the stimulus only)
  logic [2:0]  m_ack_first = 3'b001, m_ack_then = 3'b001;
  int          m_n_first = 0;
  logic [31:0] m_rd_val = '0;
  logic        m_flip = 1'b0;

  // Target model state (written by the model only)
  int          p, attempt, rises, hdrs, trn_err, idle_cnt, idle_err;
  logic [7:0]  hdr_cap;
  logic [31:0] wd_cap;
  logic        wpar_cap;
  logic        prev_swclk;

  function automatic logic [2:0] cur_ack(input int a);
    return (a < m_n_first) ? m_ack_first : m_ack_then;
  endfunction

  always @(negedge clk) begin
    if (start) begin
      p = 0; attempt = 0; rises = 0; hdrs = 0; trn_err = 0;
      idle_cnt = 0; idle_err = 0; hdr_cap = '0; wd_cap = '0; wpar_cap = 1'b0;
    end else if (swclk && !prev_swclk) begin
      rises++;
      if (p == 0) hdrs++;
      if (p < 8) begin
        hdr_cap[p] = swdio_out;
        if (!swdio_oe) trn_err++;
      end
      if (p >= 8 && p <= 11 && swdio_oe) trn_err++;
      if (cur_ack(attempt) == 3'b001) begin
        if (cmd_rnw) begin
          if (p >= 12 && p <= 45 && swdio_oe) trn_err++;
        end else begin
          if (p == 12 && swdio_oe) trn_err++;
          if (p >= 13 && p <= 44) wd_cap[p-13] = swdio_out;
          if (p == 45) wpar_cap = swdio_out;
          if (p >= 46 && p <= 53) begin
            idle_cnt++;
            if (!(swdio_oe && !swdio_out)) idle_err++;
          end
        end
      end else if (p == 12 && swdio_oe) trn_err++;
      if (p == 12 && cur_ack(attempt) != 3'b001) begin
        p = 0; attempt++;
      end else p++;
    end else if (!swclk && prev_swclk) begin
      logic [2:0] a;
      a = cur_ack(attempt);
      if (p >= 9 && p <= 11) swdio_in = a[p-9];
      else if (cmd_rnw && a == 3'b001 && p >= 12 && p <= 43) swdio_in = m_rd_val[p-12];
      else if (cmd_rnw && a == 3'b001 && p == 44) swdio_in = (^m_rd_val) ^ m_flip;
      else swdio_in = 1'b0;
    end
    prev_swclk = swclk;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic rnw, input logic ap, input logic [1:0] addr, input logic [31:0] wd,
                     input logic [2:0] a_first, input int n_first, input logic [2:0] a_then,
                     input logic [31:0] rv, input logic flip);
    @(negedge clk);
    cmd_rnw = rnw; cmd_ap = ap; cmd_addr = addr; cmd_wdata = wd;
    m_ack_first = a_first; m_n_first = n_first; m_ack_then = a_then;
    m_rd_val = rv; m_flip = flip;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_hdr(input logic rnw, input logic ap, input logic [1:0] addr);
    return {1'b1, 1'b0, ap ^ rnw ^ addr[0] ^ addr[1], addr[1], addr[0], rnw, ap, 1'b1};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(!busy && !swclk && !swdio_oe && !done, "R10 reset idle",
          {busy, swclk, swdio_oe, done}, 4'b0000);

    // R1 header sweep over all direction/port/address combinations
    for (int k = 0; k < 16; k++) begin
      logic r, a; logic [1:0] ad;
      r = k[3]; a = k[2]; ad = k[1:0];
      run(r, a, ad, 32'h0000_00FF, 3'b001, 0, 3'b001, 32'hCAFE_0001, 1'b0);
      check(hdr_cap == exp_hdr(r, a, ad), "R1 header", hdr_cap, exp_hdr(r, a, ad));
      check(status == 3'd0 && trn_err == 0, "R2 turnaround/status", {status, 8'(trn_err)}, 0);
    end

    // R3 write framing
    run(1'b0, 1'b1, 2'd2, 32'hA5C3_0F17, 3'b001, 0, 3'b001, '0, 1'b0);
    check(wd_cap == 32'hA5C3_0F17, "R3 write data", wd_cap, 32'hA5C3_0F17);
    check(wpar_cap == ^32'hA5C3_0F17, "R3 write parity", wpar_cap, ^32'hA5C3_0F17);
    check(idle_cnt == 8 && idle_err == 0, "R3 idle low clocks", {idle_cnt, idle_err}, {32'd8, 32'd0});
    check(rises == 54 && status == 3'd0, "R3 write length", rises, 54);
    check(trn_err == 0, "R2 write turnarounds", trn_err, 0);
    run(1'b0, 1'b0, 2'd1, 32'h0000_0001, 3'b001, 0, 3'b001, '0, 1'b0);
    check(wpar_cap == 1'b1 && wd_cap == 32'h1, "R3 odd parity word", {wd_cap, wpar_cap}, {32'h1, 1'b1});

    // R4 read
    run(1'b1, 1'b1, 2'd3, '0, 3'b001, 0, 3'b001, 32'h1234_5679, 1'b0);
    check(rdata == 32'h1234_5679 && status == 3'd0, "R4 read data", rdata, 32'h1234_5679);
    check(rises == 46 && trn_err == 0, "R4 read length", rises, 46);

    // R5 parity error
    run(1'b1, 1'b0, 2'd0, '0, 3'b001, 0, 3'b001, 32'h8000_0003, 1'b1);
    check(status == 3'd4 && rdata == 0, "R5 parity error", {status, rdata}, {3'd4, 32'd0});
    run(1'b1, 1'b0, 2'd0, '0, 3'b001, 0, 3'b001, 32'h0, 1'b0);
    check(status == 3'd0, "R9 dp clears", status, 0);

    // R6 two waits then OK
    run(1'b1, 1'b1, 2'd1, '0, 3'b010, 2, 3'b001, 32'h0BAD_F00D, 1'b0);
    check(status == 3'd0 && rdata == 32'h0BAD_F00D, "R6 retry read", rdata, 32'h0BAD_F00D);
    check(hdrs == 3 && rises == 72, "R6 retry attempts", {hdrs, rises}, {32'd3, 32'd72});
    check(hdr_cap == exp_hdr(1'b1, 1'b1, 2'd1), "R6 header resent", hdr_cap, exp_hdr(1'b1, 1'b1, 2'd1));

    // R7 wait until budget exhausted
    run(1'b0, 1'b1, 2'd0, 32'h1, 3'b010, 0, 3'b010, '0, 1'b0);
    check(status == 3'd1 && rdata == 0, "R7 wait timeout", status, 1);
    check(hdrs == TRIES, "R7 attempt budget", hdrs, TRIES);

    // R9 refused access-port command
    run(1'b1, 1'b1, 2'd0, '0, 3'b001, 0, 3'b001, 32'hFFFF_FFFF, 1'b0);
    check(status == 3'd2 && rdata == 0 && rises == 0, "R9 refused ap", {status, 8'(rises)}, {3'd2, 8'd0});
    run(1'b0, 1'b0, 2'd0, 32'h1E, 3'b001, 0, 3'b001, '0, 1'b0);
    check(status == 3'd0 && rises == 54, "R9 dp runs while sticky", rises, 54);
    run(1'b1, 1'b1, 2'd0, '0, 3'b001, 0, 3'b001, 32'h5555_AAAA, 1'b0);
    check(status == 3'd0 && rdata == 32'h5555_AAAA, "R9 ap after clear", rdata, 32'h5555_AAAA);

    // R7 fault exhausted
    run(1'b1, 1'b0, 2'd1, '0, 3'b100, 0, 3'b100, '0, 1'b0);
    check(status == 3'd2 && hdrs == TRIES, "R7 fault exhausted", {status, 8'(hdrs)}, {3'd2, 8'(TRIES)});
    run(1'b0, 1'b0, 2'd0, 32'h1E, 3'b001, 0, 3'b001, '0, 1'b0);

    // R6 one fault then OK
    run(1'b0, 1'b1, 2'd3, 32'h7, 3'b100, 1, 3'b001, '0, 1'b0);
    check(status == 3'd0 && hdrs == 2 && wd_cap == 32'h7, "R6 fault retry", hdrs, 2);

    // R8 no response and invalid codes
    run(1'b1, 1'b0, 2'd0, '0, 3'b111, 0, 3'b111, '0, 1'b0);
    check(status == 3'd3 && hdrs == 1, "R8 no response", {status, 8'(hdrs)}, {3'd3, 8'd1});
    run(1'b1, 1'b0, 2'd0, '0, 3'b001, 0, 3'b001, 32'h0, 1'b0);
    run(1'b1, 1'b0, 2'd2, '0, 3'b011, 0, 3'b011, '0, 1'b0);
    check(status == 3'd5 && hdrs == 1, "R8 invalid ack", {status, 8'(hdrs)}, {3'd5, 8'd1});
    run(1'b1, 1'b0, 2'd0, '0, 3'b000, 0, 3'b000, '0, 1'b0);
    check(status == 3'd5 && hdrs == 1 && rdata == 0, "R8 zero ack", {status, 8'(hdrs)}, {3'd5, 8'd1});

    @(negedge clk);
    check(!done && !busy && !swclk && !swdio_oe, "R10 idle after done", {done, busy, swclk, swdio_oe}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule